// File: doc/BRIEF.md
# Strap-Latched PCI Clock Ratio Selector

This block comes out of power-on reset and reads a four-bit frequency strap and a one-bit mode strap. It samples them once, on the first clock edge after reset is released. The same pins are later driven as clock outputs, so the block keeps their output drivers off until the sample has been taken. The mode strap decides what a shared pin becomes: a clock-stop input or a reference clock output.

A select bit in a configuration byte chooses where the active operating-point code comes from: the latched straps or a software field in the same byte. The code sets the integer ratio (2, 3 or 4) between the fast CPU-rate clock and the derived PCI clock. The divider moves to a new ratio only at the end of a whole PCI period, so the divided clock never carries a runt pulse. The block also passes on a global tristate request and a spread-enable flag. It returns the captured straps in inverted form so that they can be read back.

Top module: `clk_ratio_sel`

## Requirements
- R1: The straps and the mode strap are sampled only on the first clock edge after reset is released. Later changes on `strap_fs_i` or `strap_mode_i` leave `fs_inv_o` and `mode_o` unchanged until the next reset.
- R2: `fs_inv_o` is the bitwise inverse of the captured strap value. Before capture the straps read as all ones (pull-ups), so `fs_inv_o` is 0.
- R3: `fs_pin_oe_o` is 0 during reset and until the straps are captured. After capture it is 1 unless the tristate bit (cfg bit 0) is set.
- R4: `mode_o` holds the captured mode strap. With mode 0, `stop_in_en_o`=1 and `ref_oe_o`=0. With mode 1, `stop_in_en_o`=0 and `ref_oe_o`=1, except while tristated. Both are 0 before capture.
- R5: With cfg bit 3 at 0, the active code is the captured straps. With cfg bit 3 at 1, the code is {cfg[2], cfg[6:4]}. `code_o` shows the active code one clock after cfg changes.
- R6: Ratio by code: 15, 14, 13, 10, 7, 6 and 5 give 2; 12, 11, 8, 4, 3 and 2 give 3; 1 and 0 give 4.
- R7: Code 9 gives ratio 2 when taken from the straps and ratio 3 when taken from software.
- R8: The divided clock is high for floor(N/2) CPU cycles at the start of each period of N cycles: /2 is 1 high, 1 low; /3 is 1 high, 2 low; /4 is 2 high, 2 low. The first period starts two edges after reset is released.
- R9: A change of the target ratio takes effect only at the end of the current PCI period. `ratio_o` reports the ratio in force.
- R10: `spread_o` follows cfg bit 1 and `tristate_o` follows cfg bit 0, each one clock later.
- R11: During reset, `pci_clk_o`, `fs_pin_oe_o`, `ref_oe_o`, `stop_in_en_o`, `spread_o` and `tristate_o` are 0, and `ratio_o` is 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU-rate clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| strap_fs_i | input | 4 | Frequency strap pins, read at power-up |
| strap_mode_i | input | 1 | Mode strap pin, read at power-up |
| cfg_i | input | 8 | Configuration byte: source select, software code, spread, tristate |
| pci_clk_o | output | 1 | Divided PCI clock |
| ratio_o | output | 3 | Divide ratio in force |
| code_o | output | 4 | Active operating-point code |
| fs_inv_o | output | 4 | Inverted captured straps for readback |
| mode_o | output | 1 | Captured mode strap |
| fs_pin_oe_o | output | 1 | Output enable for the strap pins |
| ref_oe_o | output | 1 | Output enable for the shared pin as reference clock |
| stop_in_en_o | output | 1 | Shared pin used as clock-stop input |
| spread_o | output | 1 | Spread-enable flag |
| tristate_o | output | 1 | Global tristate request |

## Verification
The divider is driven through the strap code 9, then the software code 9, then the software code 0. This shows the /2, /3 and /4 waveforms and separates the two tables at the one code where they disagree. The software code is changed in the middle of a PCI period, which shows whether the switch waits for the period boundary. The strap pins are toggled after capture, which shows that the straps are sampled only once. A second power-up with the other mode strap and a /3 strap code exercises the shared-pin handover in both directions.

// File: rtl/clk_ratio_pkg.sv
package clk_ratio_pkg;
  localparam int FS_W    = 4;
  localparam int DIV_W   = 3;
  localparam int CFG_W   = 8;
  localparam int SRC_BIT = 3;
  localparam int SW_MSB  = 2;
  localparam int SW_LO_H = 6;
  localparam int SW_LO_L = 4;
  localparam int SPR_BIT = 1;
  localparam int TRI_BIT = 0;

  typedef logic [FS_W-1:0]  code_t;
  typedef logic [DIV_W-1:0] div_t;

  function automatic div_t ratio_of(input code_t c, input logic from_sw);
    div_t r;
    case (c)
      4'hF, 4'hE, 4'hD, 4'hA, 4'h7, 4'h6, 4'h5: r = div_t'(2);
      4'h9:                                     r = from_sw ? div_t'(3) : div_t'(2);
      4'hC, 4'hB, 4'h8, 4'h4, 4'h3, 4'h2:       r = div_t'(3);
      default:                                  r = div_t'(4);
    endcase
    return r;
  endfunction
endpackage

// File: rtl/strap_latch.sv
module strap_latch
  import clk_ratio_pkg::*;
#(
  parameter int W = FS_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] fs_pin_i,
  input  logic         mode_pin_i,
  output logic [W-1:0] fs_q_o,
  output logic         mode_q_o,
  output logic         cap_o
);
  logic [W-1:0] fs_q;
  logic         mode_q;
  logic         cap_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      fs_q   <= '1;
      mode_q <= 1'b1;
      cap_q  <= 1'b0;
    end else if (!cap_q) begin
      fs_q   <= fs_pin_i;
      mode_q <= mode_pin_i;
      cap_q  <= 1'b1;
    end
  end

  assign fs_q_o   = fs_q;
  assign mode_q_o = mode_q;
  assign cap_o    = cap_q;

  assert_strap_frozen_R1: assert property (@(posedge clk) disable iff (rst)
    (cap_q && $past(cap_q)) |-> ($stable(fs_q) && $stable(mode_q)));

  assert_capture_sample_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(cap_q) |-> (fs_q == $past(fs_pin_i)));
endmodule

// File: rtl/code_mux.sv
module code_mux
  import clk_ratio_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  code_t            fs_i,
  input  logic [CFG_W-1:0] cfg_i,
  output div_t             tgt_div_o,
  output code_t            code_o,
  output logic             spread_o,
  output logic             tri_o
);
  logic  use_sw;
  code_t sw_code;
  code_t act_code;
  code_t code_q;
  logic  spr_q;
  logic  tri_q;

  assign use_sw    = cfg_i[SRC_BIT];
  assign sw_code   = {cfg_i[SW_MSB], cfg_i[SW_LO_H:SW_LO_L]};
  assign act_code  = use_sw ? sw_code : fs_i;
  assign tgt_div_o = ratio_of(act_code, use_sw);

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= '0;
      spr_q  <= 1'b0;
      tri_q  <= 1'b0;
    end else begin
      code_q <= act_code;
      spr_q  <= cfg_i[SPR_BIT];
      tri_q  <= cfg_i[TRI_BIT];
    end
  end

  assign code_o   = code_q;
  assign spread_o = spr_q;
  assign tri_o    = tri_q;

  assert_tri_follows_R10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (tri_q == $past(cfg_i[TRI_BIT])));

  assert_target_legal_R6: assert property (@(posedge clk) disable iff (rst)
    (tgt_div_o >= div_t'(2)) && (tgt_div_o <= div_t'(4)));
endmodule

// File: rtl/pci_divider.sv
module pci_divider
  import clk_ratio_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  input  div_t tgt_i,
  output div_t div_o,
  output logic pci_o
);
  div_t cnt_q;
  div_t div_q;
  div_t cnt_nx;
  logic run_q;
  logic pci_q;

  assign cnt_nx = cnt_q + div_t'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      cnt_q <= '0;
      div_q <= div_t'(2);
      pci_q <= 1'b0;
    end else if (!run_q) begin
      if (en_i) begin
        run_q <= 1'b1;
        div_q <= tgt_i;
        cnt_q <= '0;
        pci_q <= 1'b1;
      end
    end else if (cnt_nx == div_q) begin
      cnt_q <= '0;
      div_q <= tgt_i;
      pci_q <= 1'b1;
    end else begin
      cnt_q <= cnt_nx;
      pci_q <= (cnt_nx < (div_q >> 1));
    end
  end

  assign div_o = div_q;
  assign pci_o = pci_q;

  assert_switch_at_wrap_R9: assert property (@(posedge clk) disable iff (rst)
    (run_q && $past(run_q) && (div_q != $past(div_q)))
      |-> ($past(cnt_q) == $past(div_q) - div_t'(1)));

  assert_rise_aligned_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(pci_q) |-> (cnt_q == '0));

  assert_ratio_legal_R6: assert property (@(posedge clk) disable iff (rst)
    run_q |-> ((div_q >= div_t'(2)) && (div_q <= div_t'(4))));
endmodule

// File: rtl/clk_ratio_sel.sv
module clk_ratio_sel
  import clk_ratio_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [FS_W-1:0]  strap_fs_i,
  input  logic             strap_mode_i,
  input  logic [CFG_W-1:0] cfg_i,
  output logic             pci_clk_o,
  output logic [DIV_W-1:0] ratio_o,
  output logic [FS_W-1:0]  code_o,
  output logic [FS_W-1:0]  fs_inv_o,
  output logic             mode_o,
  output logic             fs_pin_oe_o,
  output logic             ref_oe_o,
  output logic             stop_in_en_o,
  output logic             spread_o,
  output logic             tristate_o
);
  code_t fs_q;
  logic  mode_q;
  logic  cap;
  div_t  tgt_div;
  logic  tri_q;

  strap_latch #(.W(FS_W)) u_strap (
    .clk(clk), .rst(rst), .fs_pin_i(strap_fs_i), .mode_pin_i(strap_mode_i),
    .fs_q_o(fs_q), .mode_q_o(mode_q), .cap_o(cap)
  );

  code_mux u_mux (
    .clk(clk), .rst(rst), .fs_i(fs_q), .cfg_i(cfg_i),
    .tgt_div_o(tgt_div), .code_o(code_o), .spread_o(spread_o), .tri_o(tri_q)
  );

  pci_divider u_div (
    .clk(clk), .rst(rst), .en_i(cap), .tgt_i(tgt_div),
    .div_o(ratio_o), .pci_o(pci_clk_o)
  );

  assign tristate_o   = tri_q;
  assign fs_inv_o     = ~fs_q;
  assign mode_o       = mode_q;
  assign fs_pin_oe_o  = cap & ~tri_q;
  assign ref_oe_o     = cap & mode_q & ~tri_q;
  assign stop_in_en_o = cap & ~mode_q;

  assert_shared_pin_excl_R4: assert property (@(posedge clk) disable iff (rst)
    !(ref_oe_o && stop_in_en_o));
endmodule

// File: tb/clk_ratio_sel_bench.sv
module clk_ratio_sel_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] strap_fs = 4'b1001;
  logic       strap_mode = 1'b0;
  logic [7:0] cfg = 8'h00;
  logic       pci_clk_o, mode_o, fs_pin_oe_o, ref_oe_o, stop_in_en_o, spread_o, tristate_o;
  logic [2:0] ratio_o;
  logic [3:0] code_o, fs_inv_o;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 0;

  clk_ratio_sel u_clk_ratio_sel (
    .clk(clk), .rst(rst), .strap_fs_i(strap_fs), .strap_mode_i(strap_mode), .cfg_i(cfg),
    .pci_clk_o(pci_clk_o), .ratio_o(ratio_o), .code_o(code_o), .fs_inv_o(fs_inv_o),
    .mode_o(mode_o), .fs_pin_oe_o(fs_pin_oe_o), .ref_oe_o(ref_oe_o),
    .stop_in_en_o(stop_in_en_o), .spread_o(spread_o), .tristate_o(tristate_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Reference model state
  int   m_cap, m_run, m_ph, m_div, m_code, m_spr, m_tri, m_mode;
  int   m_fs;

  function automatic int ref_ratio(int c, bit sw);
    if (c <= 1) return 4;
    if (c == 9) return sw ? 3 : 2;
    if (c >= 2 && c <= 4) return 3;
    if (c >= 5 && c <= 7) return 2;
    if (c == 8 || c == 11 || c == 12) return 3;
    return 2;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_fs = 15; m_mode = 1; m_cap = 0; m_run = 0; m_ph = 0; m_div = 2;
      m_code = 0; m_spr = 0; m_tri = 0;
    end else begin
      int  c;
      bit  sw;
      sw = cfg[3];
      c  = sw ? {cfg[2], cfg[6:4]} : m_fs;
      if (!m_run) begin
        if (m_cap != 0) begin m_run = 1; m_ph = 0; m_div = ref_ratio(c, sw); end
      end else begin
        m_ph = m_ph + 1;
        if (m_ph == m_div) begin m_ph = 0; m_div = ref_ratio(c, sw); end
      end
      if (m_cap == 0) begin m_fs = strap_fs; m_mode = strap_mode; m_cap = 1; end
      m_code = c; m_spr = cfg[1]; m_tri = cfg[0];
    end
  end

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      chk("R8 R9 pci_clk", pci_clk_o, (m_run != 0 && m_ph < m_div / 2) ? 1 : 0);
      chk("R6 ratio", ratio_o, m_div);
      chk("R5 code", code_o, m_code);
      chk("R1 R2 fs_inv", fs_inv_o, (~m_fs) & 15);
      chk("R4 mode", mode_o, m_mode);
      chk("R3 fs_pin_oe", fs_pin_oe_o, (m_cap != 0 && m_tri == 0) ? 1 : 0);
      chk("R4 ref_oe", ref_oe_o, (m_cap != 0 && m_mode != 0 && m_tri == 0) ? 1 : 0);
      chk("R4 stop_in_en", stop_in_en_o, (m_cap != 0 && m_mode == 0) ? 1 : 0);
      chk("R10 spread", spread_o, m_spr);
      chk("R10 tristate", tristate_o, m_tri);
    end
  end

  task automatic wait_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      failures++;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      finish_run();
    end
  end

  initial begin
    wait_cycles(4);
    // R11: reset values
    chk("R11 pci in reset", pci_clk_o, 0);
    chk("R11 oe in reset", fs_pin_oe_o | ref_oe_o | stop_in_en_o, 0);
    chk("R11 ratio in reset", ratio_o, 2);
    rst = 1'b0;
    wait_cycles(20);
    // R7: strap code 9 gives /2
    chk("R7 strap code 9 ratio", ratio_o, 2);
    chk("R2 strap readback", fs_inv_o, 4'b0110);
    // R1: later strap changes ignored
    strap_fs = 4'b0000; strap_mode = 1'b1;
    wait_cycles(6);
    chk("R1 straps frozen", fs_inv_o, 4'b0110);
    chk("R1 mode frozen", mode_o, 0);
    // R7: software code 9 gives /3
    cfg = 8'h1C;
    wait_cycles(20);
    chk("R7 software code 9 ratio", ratio_o, 3);
    // R9: change mid-period to software code 0 (/4)
    @(posedge pci_clk_o);
    @(negedge clk);
    cfg = 8'h08;
    wait_cycles(24);
    chk("R6 software code 0 ratio", ratio_o, 4);
    cfg = 8'h0A;
    wait_cycles(6);
    chk("R10 spread set", spread_o, 1);
    cfg = 8'h09;
    wait_cycles(6);
    chk("R3 tristate drops oe", fs_pin_oe_o, 0);
    cfg = 8'h48;
    wait_cycles(12);
    // second power-up: mode 1, strap code 4 (/3)
    rst = 1'b1; cfg = 8'h00; strap_fs = 4'b0100; strap_mode = 1'b1;
    wait_cycles(3);
    rst = 1'b0;
    wait_cycles(20);
    chk("R4 ref_oe with mode 1", ref_oe_o, 1);
    chk("R4 stop input off with mode 1", stop_in_en_o, 0);
    chk("R6 strap code 4 ratio", ratio_o, 3);
    chk("R5 strap code active", code_o, 4);
    finish_run();
  end
endmodule